// File: doc/BRIEF.md
# Header-Routed Stream Demultiplexer

This block collects packets from a parameterized set of AXI4-Stream inputs and steers each packet's payload to one of four AXI4-Stream outputs. Each packet begins with a header word. The two lowest bits of the header choose the output lane. The header itself is consumed and is never forwarded. Every word that follows, up to and including the word with TLAST set, goes to the chosen lane.

The inputs are visited in a fixed ascending order. The block takes exactly four packets from the current input and then moves to the next one. After the last input it wraps back to input 0, which starts a new iteration. Only the input being visited is ever given TREADY. While a payload is moving, that input's TREADY follows the selected output's TREADY, so back-pressure passes straight through without a buffer.

The controller has two states. In `ST_HDR` it waits for a header word on the current input, with TREADY held high. A header handshake takes the transition *header-accept* to `ST_BODY` and latches the lane. In `ST_BODY` payload words pass through to the latched lane. A handshake on a word with TLAST set takes the transition *packet-end* back to `ST_HDR`. On *packet-end* the per-input packet count advances. When that count completes four, the input index steps forward instead, and wraps to 0 after the last input.

Top module: `hdr_stream_router`

## Requirements
- R1: After reset the block is in the header state on input 0: `s_tready` equals one-hot bit 0 and every `m_tvalid` bit is low.
- R2: A header word is consumed with TREADY high, and no output shows TVALID while the block waits for a header.
- R3: A header whose bits [1:0] are 0, 1, 2 or 3 sends the payload of that packet to output lane 0, 1, 2 or 3 respectively (lane n is `m_tdata[n*DATA_W +: DATA_W]`, `m_tvalid[n]`, `m_tlast[n]`, `m_tready[n]`). Data is passed unchanged and no other lane shows TVALID.
- R4: Header bits above bit 1 have no effect on routing.
- R5: TLAST is passed through on the routed word, and the input word after a TLAST handshake is treated as the next header.
- R6: During a payload, TREADY of the current input equals TREADY of the selected output lane, and a word is taken only on a handshake at both ends.
- R7: Exactly four packets are taken from each input before the next input (index + 1) is served.
- R8: After input NUM_RX-1 completes its four packets, service returns to input 0.
- R9: At most one input has TREADY high in any cycle, and only the input being served does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | NUM_RX*DATA_W | Input stream data, stream i at bits [i*DATA_W +: DATA_W] |
| s_tvalid | input | NUM_RX | Input stream TVALID, one per input |
| s_tlast | input | NUM_RX | Input stream TLAST, one per input |
| s_tready | output | NUM_RX | Input stream TREADY, one per input |
| m_tdata | output | 4*DATA_W | Output lane data, lane n at bits [n*DATA_W +: DATA_W] |
| m_tvalid | output | 4 | Output lane TVALID |
| m_tlast | output | 4 | Output lane TLAST |
| m_tready | input | 4 | Output lane TREADY |

## Verification
The bench feeds every input a stream of packets. Each header carries random upper bits over a random lane code, and each packet has a random length of one to four words. This separates routing by the low bits from any dependence on the upper bits. Sources pause TVALID at random, which checks that inputs other than the current one are left untouched. Output lanes drop TREADY at random, which shows whether back-pressure reaches exactly the served input. Three inputs are used, so the four-packet count and the wrap to input 0 both occur many times in one run.

// File: rtl/hdr_route_pkg.sv
package hdr_route_pkg;
    localparam int NUM_TX      = 4;
    localparam int PKTS_PER_RX = 4;
    localparam int SEL_W       = $clog2(NUM_TX);
    localparam int CNT_W       = $clog2(PKTS_PER_RX);

    typedef enum logic {
        ST_HDR  = 1'b0,
        ST_BODY = 1'b1
    } rt_state_e;
endpackage

// File: rtl/rx_select.sv
module rx_select #(
    parameter int NUM_RX = 100,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 7
) (
    input  logic [NUM_RX*DATA_W-1:0] s_tdata,
    input  logic [NUM_RX-1:0]        s_tvalid,
    input  logic [NUM_RX-1:0]        s_tlast,
    output logic [NUM_RX-1:0]        s_tready,
    input  logic [IDX_W-1:0]         idx,
    input  logic                     cur_ready,
    output logic [DATA_W-1:0]        cur_data,
    output logic                     cur_valid,
    output logic                     cur_last
);
    logic [NUM_RX-1:0] hit;

    for (genvar g = 0; g < NUM_RX; g++) begin : g_hit
        assign hit[g]      = (idx == IDX_W'(g));
        assign s_tready[g] = hit[g] & cur_ready;
    end

    always_comb begin
        cur_data  = '0;
        cur_valid = 1'b0;
        cur_last  = 1'b0;
        for (int i = 0; i < NUM_RX; i++) begin
            if (hit[i]) begin
                cur_data  = s_tdata[i*DATA_W +: DATA_W];
                cur_valid = s_tvalid[i];
                cur_last  = s_tlast[i];
            end
        end
    end

    // R9: only the served input may see TREADY
    always_comb begin
        a_r9_one_ready: assert ($onehot0(s_tready));
    end
endmodule

// File: rtl/tx_demux.sv
module tx_demux
    import hdr_route_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                     body,
    input  logic [SEL_W-1:0]         sel,
    input  logic [DATA_W-1:0]        cur_data,
    input  logic                     cur_valid,
    input  logic                     cur_last,
    output logic                     body_ready,
    output logic [NUM_TX*DATA_W-1:0] m_tdata,
    output logic [NUM_TX-1:0]        m_tvalid,
    output logic [NUM_TX-1:0]        m_tlast,
    input  logic [NUM_TX-1:0]        m_tready
);
    for (genvar g = 0; g < NUM_TX; g++) begin : g_lane
        logic pick;
        assign pick                       = body && (sel == SEL_W'(g));
        assign m_tvalid[g]                = pick & cur_valid;
        assign m_tlast[g]                 = pick & cur_last;
        assign m_tdata[g*DATA_W +: DATA_W] = cur_data;
    end

    assign body_ready = body & m_tready[sel];

    // R3: at most one lane presents data
    always_comb begin
        a_r3_one_lane: assert ($onehot0(m_tvalid));
    end
endmodule

// File: rtl/route_fsm.sv
module route_fsm
    import hdr_route_pkg::*;
#(
    parameter int NUM_RX = 100,
    parameter int IDX_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cur_valid,
    input  logic             cur_last,
    input  logic [SEL_W-1:0] hdr_sel,
    input  logic             body_ready,
    output rt_state_e        state,
    output logic [IDX_W-1:0] idx,
    output logic [SEL_W-1:0] sel,
    output logic             cur_ready
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RX - 1);
    localparam logic [CNT_W-1:0] LAST_PKT = CNT_W'(PKTS_PER_RX - 1);

    logic [CNT_W-1:0] pkt_cnt;
    logic             hdr_fire;
    logic             end_fire;

    assign hdr_fire = (state == ST_HDR) && cur_valid;
    assign end_fire = (state == ST_BODY) && cur_valid && body_ready && cur_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_HDR;
            idx     <= '0;
            pkt_cnt <= '0;
            sel     <= '0;
        end else begin
            unique case (state)
                ST_HDR: if (hdr_fire) begin
                    sel   <= hdr_sel;
                    state <= ST_BODY;
                end
                ST_BODY: if (end_fire) begin
                    state <= ST_HDR;
                    if (pkt_cnt == LAST_PKT) begin
                        pkt_cnt <= '0;
                        idx     <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
                    end else begin
                        pkt_cnt <= pkt_cnt + 1'b1;
                    end
                end
                default: state <= ST_HDR;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_HDR:  cur_ready = 1'b1;
            ST_BODY: cur_ready = body_ready;
            default: cur_ready = 1'b0;
        endcase
    end

    // R7: index moves only when a fourth packet ends
    a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx) |-> $past(end_fire && pkt_cnt == LAST_PKT));
    // R8: leaving the last input goes to input 0
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(idx) == LAST_IDX && !$stable(idx)) |-> idx == '0);
    // R5: a TLAST handshake returns to header state
    a_r5_last_to_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        end_fire |=> state == ST_HDR);
    // R3: lane held for the whole payload
    a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY && $past(state) == ST_BODY) |-> $stable(sel));
endmodule

// File: rtl/hdr_stream_router.sv
module hdr_stream_router
    import hdr_route_pkg::*;
#(
    parameter int NUM_RX = 100,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_RX*DATA_W-1:0] s_tdata,
    input  logic [NUM_RX-1:0]        s_tvalid,
    input  logic [NUM_RX-1:0]        s_tlast,
    output logic [NUM_RX-1:0]        s_tready,
    output logic [4*DATA_W-1:0]      m_tdata,
    output logic [3:0]               m_tvalid,
    output logic [3:0]               m_tlast,
    input  logic [3:0]               m_tready
);
    localparam int IDX_W = (NUM_RX > 1) ? $clog2(NUM_RX) : 1;

    rt_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel;
    logic             cur_ready, cur_valid, cur_last, body_ready;
    logic [DATA_W-1:0] cur_data;

    rx_select #(.NUM_RX(NUM_RX), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
        .s_tdata  (s_tdata),
        .s_tvalid (s_tvalid),
        .s_tlast  (s_tlast),
        .s_tready (s_tready),
        .idx      (idx),
        .cur_ready(cur_ready),
        .cur_data (cur_data),
        .cur_valid(cur_valid),
        .cur_last (cur_last)
    );

    route_fsm #(.NUM_RX(NUM_RX), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_valid (cur_valid),
        .cur_last  (cur_last),
        .hdr_sel   (cur_data[SEL_W-1:0]),
        .body_ready(body_ready),
        .state     (state),
        .idx       (idx),
        .sel       (sel),
        .cur_ready (cur_ready)
    );

    tx_demux #(.DATA_W(DATA_W)) u_dmx (
        .body      (state == ST_BODY),
        .sel       (sel),
        .cur_data  (cur_data),
        .cur_valid (cur_valid),
        .cur_last  (cur_last),
        .body_ready(body_ready),
        .m_tdata   (m_tdata),
        .m_tvalid  (m_tvalid),
        .m_tlast   (m_tlast),
        .m_tready  (m_tready)
    );

    // R2: header words never appear on an output
    a_r2_hdr_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR) |-> (m_tvalid == '0));
    // R6: payload back-pressure follows the chosen lane
    a_r6_bp_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY) |-> (s_tready[idx] == m_tready[sel]));
endmodule

// File: tb/sim_hdr_stream_router.sv
module sim_hdr_stream_router;
    localparam int N  = 3;
    localparam int DW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N*DW-1:0]   s_tdata = '0;
    logic [N-1:0]      s_tvalid = '0, s_tlast = '0, s_tready;
    logic [4*DW-1:0]   m_tdata;
    logic [3:0]        m_tvalid, m_tlast;
    logic [3:0]        m_tready = '0;

    int tests = 0, fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    hdr_stream_router #(.NUM_RX(N), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready)
    );

    // reference model state
    int midx = 0, mcnt = 0, msel = 0;
    bit mhdr = 1;
    int  hdr_hi_seen = 0, wraps = 0;
    logic [DW:0] q [N][$];           // {last, data}

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic refill(input int i);
        int len;
        logic [DW-1:0] h;
        h = DW'($urandom);
        q[i].push_back({1'b0, h});
        len = 1 + int'($urandom % 4);
        for (int k = 0; k < len; k++)
            q[i].push_back({(k == len - 1), DW'($urandom)});
    endtask

    initial begin
        logic [N-1:0]  exp_rdy, pv, pr;
        logic [3:0]    exp_vld, pm;
        logic [DW:0]   front;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 s_tready", 64'(s_tready), 64'(3'b001));
        chk("R1 m_tvalid", 64'(m_tvalid), 64'h0);
        pv = '0; pr = '0; pm = '0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            // advance model with last cycle's handshakes
            if (pv[midx] && pr[midx]) begin
                front = q[midx].pop_front();
                if (mhdr) begin
                    msel = int'(front[1:0]);
                    if (front[DW-1:2] != '0) hdr_hi_seen++;
                    mhdr = 0;
                end else if (front[DW]) begin
                    mhdr = 1;
                    if (mcnt == 3) begin
                        mcnt = 0;
                        midx = (midx == N - 1) ? 0 : midx + 1;
                        if (midx == 0) wraps++;
                    end else mcnt++;
                end
            end
            for (int i = 0; i < N; i++) if (pv[i] && !pr[i]) ; // hold
            // drive new inputs
            for (int i = 0; i < N; i++) begin
                if (q[i].size() < 2) refill(i);
                if (!(pv[i] && !pr[i])) s_tvalid[i] = ($urandom % 4) != 0;
                front = q[i][0];
                s_tdata[i*DW +: DW] = front[DW-1:0];
                s_tlast[i] = front[DW];
            end
            m_tready = 4'($urandom) | 4'($urandom);
            #1;
            exp_rdy = '0; exp_vld = '0;
            if (mhdr) exp_rdy[midx] = 1'b1;
            else begin
                exp_rdy[midx] = m_tready[msel];
                exp_vld[msel] = s_tvalid[midx];
            end
            if (mhdr) chk("R2 no output during header", 64'(m_tvalid), 64'h0);
            else      chk("R3 R4 lane valid", 64'(m_tvalid), 64'(exp_vld));
            chk("R6 R7 R8 R9 s_tready", 64'(s_tready), 64'(exp_rdy));
            if (!mhdr && s_tvalid[midx]) begin
                chk("R3 lane data", 64'(m_tdata[msel*DW +: DW]), 64'(s_tdata[midx*DW +: DW]));
                chk("R5 lane last", 64'(m_tlast[msel]), 64'(s_tlast[midx]));
            end
            pv = s_tvalid; pr = exp_rdy; pm = m_tready;
        end
        // R4 and R8 were reached by the stimulus
        chk("R4 headers with upper bits seen", 64'(hdr_hi_seen > 0), 64'h1);
        chk("R8 wraps to input 0 seen", 64'(wraps > 0), 64'h1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule